// File: doc/BRIEF.md
# SPI Preselection Router with Local Control Registers

This block is a 3-wire SPI slave that shares one host bus among several downstream SPI devices and a small bank of local control registers. The host opens every cycle by pulling its chip select low and shifting a routing byte. The block decodes that byte. It then does one of three things for the rest of the cycle: it passes the cycle through to one downstream device, it serves the cycle from its own registers, or it discards the cycle.

The host pins are sampled by a fast system clock (`clk`), which must run at least 8 times faster than the SPI clock. Forwarded cycles leave on the shared `dsSclk`/`dsSdo` lines, and only the chosen target's chip select is pulled low. A local cycle is 24 bits long: the routing byte, an instruction byte and a data byte. The instruction byte carries a read/write flag in bit 7 (1 = read) and a 7-bit address below it. Only address bits 1:0 pick a register. The registers drive parallel outputs: clock and sync source selects, reset controls, transceiver directions, fan enables, and a status LED selector that picks which status input to show.

Top module: `spiPreselRouter`

## Requirements
- R1: After `rstN` is low, all register outputs and `ledOut` are 0, every `dsCsN` bit is 1, `dsSclk` is 0 and `spiSdioOe` is 0.
- R2: Frames are MSB first, and the block samples on rising `spiSclk`. Routing code 0x00 selects the local registers. A write to register 0 sets `clkSrcSel` from data bits 1:0, `syncSrcSel` from bit 2, `clkRst` from bit 3 and `dacRst` from bit 4. Reading register 0 returns these fields in the same positions, with bits 7:5 read as 0.
- R3: Register 1 maps data bits 3:0 to `xcvrDir`, where 1 makes that transceiver an output and 0 makes it an input. It maps data bits 7:4 to `fanEn`.
- R4: Register 2 bits 4:0 form `ledSel`. `ledOut` equals `statusIn[i]`, where i is the lowest set bit of `ledSel`. When `ledSel` is 0, `ledOut` is 0.
- R5: In a local read (instruction bit 7 = 1), the block drives `spiSdioOe` and shifts the addressed register out on `spiSdioOut`, MSB first, during the data byte. Data changes after falling `spiSclk` edges.
- R6: Routing code 0x01+k, for k below NUM_TARGETS, pulls only `dsCsN[k]` low. Every later host bit is then passed to `dsSclk`/`dsSdo`, and no local register changes.
- R7: A routing code that is neither 0x00 nor a target code is ignored. No chip select goes low, `dsSclk` stays idle, no register changes and the SDIO driver stays off.
- R8: A register write takes effect only after the 24th rising edge of the frame. If the host raises its chip select earlier, the frame is aborted and the registers keep their values.
- R9: `spiSdioOe` is 0 whenever `spiCsN` is high, including when the host ends a read early.
- R10: Instruction address bits 6:2 are ignored. Address 3 reads back as 0, and a write to it changes nothing.
- R11: When `spiCsN` goes high, all `dsCsN` bits return high, and the next frame starts again with a routing byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rstN | input | 1 | Active-low reset |
| spiCsN | input | 1 | Host chip select, active low |
| spiSclk | input | 1 | Host SPI clock |
| spiSdioIn | input | 1 | Host data line, input side |
| spiSdioOut | output | 1 | Host data line, output side (read data) |
| spiSdioOe | output | 1 | Output enable for the host data line |
| dsCsN | output | NUM_TARGETS | Downstream chip selects, active low |
| dsSclk | output | 1 | Shared downstream clock |
| dsSdo | output | 1 | Shared downstream data |
| statusIn | input | LED_W | Status sources for the LED selector |
| clkSrcSel | output | 2 | Clock source select |
| syncSrcSel | output | 1 | Sync source select |
| clkRst | output | 1 | Clock circuit reset |
| dacRst | output | 1 | Converter reset |
| xcvrDir | output | DIR_W | Front transceiver directions |
| fanEn | output | DIR_W | Fan power enables |
| ledSel | output | LED_W | LED source selector field |
| ledOut | output | 1 | Selected status bit |

## Verification
The closest collision is between committing a write and the host raising its chip select. The 24th rising edge and the chip-select rise can pass through the two-stage synchronizers only a cycle or two apart. The bench provokes this by raising `spiCsN` one system clock after the final rising edge, while `spiSclk` is still high. The write must still land. A frame cut off after 23 bits must leave the register untouched. A second overlap, a read whose driver is still on when the host aborts, is judged by requiring `spiSdioOe` to be low one clock after `spiCsN` rises.

// File: rtl/spiPreselPkg.sv
package spiPreselPkg;
  typedef enum logic [1:0] {
    ST_PRESEL,
    ST_LOCAL,
    ST_FWD,
    ST_DROP
  } frameStateT;

  typedef struct packed {
    logic sample;
    logic bitIn;
    logic latchInstr;
    logic commit;
    logic shiftTx;
  } dpStrobeT;

  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 24;
  localparam int CTRL_W     = 5;
  localparam logic [7:0] LOCAL_CODE = 8'h00;
endpackage

// File: rtl/spiFrameCtrl.sv
module spiFrameCtrl
  import spiPreselPkg::*;
#(
  parameter int NUM_TARGETS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   spiCsN,
  input  logic                   spiSclk,
  input  logic                   spiSdioIn,
  input  logic [BYTE_W-1:0]      rxByte,
  output dpStrobeT               stb,
  output logic                   sdioOe,
  output logic [NUM_TARGETS-1:0] dsCsN,
  output logic                   dsSclk,
  output logic                   dsSdo
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS);

  logic [1:0] csSync, sclkSync, sdioSync;
  logic ncsS, sclkS, sdioS, sclkPrev;
  logic rise, fall;
  logic [CNT_W-1:0] bitCnt;
  logic preselPulse, instrPulse, dataPulse;
  logic isRead, drv, fwdEn;
  frameStateT state;
  logic [NUM_TARGETS-1:0] tgtHit;
  logic [NUM_TARGETS-1:0] dsCsNq;

  assign ncsS  = csSync[1];
  assign sclkS = sclkSync[1];
  assign sdioS = sdioSync[1];
  assign rise  = ~ncsS & sclkS & ~sclkPrev;
  assign fall  = ~ncsS & ~sclkS & sclkPrev;

  always_comb begin
    for (int k = 0; k < NUM_TARGETS; k++) begin
      tgtHit[k] = (rxByte == 8'(k + 1));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= 2'b11;
      sclkSync <= 2'b00;
      sdioSync <= 2'b00;
    end else begin
      csSync   <= {csSync[0], spiCsN};
      sclkSync <= {sclkSync[0], spiSclk};
      sdioSync <= {sdioSync[0], spiSdioIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev    <= 1'b0;
      bitCnt      <= '0;
      preselPulse <= 1'b0;
      instrPulse  <= 1'b0;
      dataPulse   <= 1'b0;
      state       <= ST_PRESEL;
      isRead      <= 1'b0;
      drv         <= 1'b0;
      fwdEn       <= 1'b0;
      dsCsNq      <= '1;
    end else begin
      sclkPrev    <= sclkS;
      preselPulse <= 1'b0;
      instrPulse  <= 1'b0;
      dataPulse   <= 1'b0;
      if (ncsS) begin
        bitCnt <= '0;
        state  <= ST_PRESEL;
        isRead <= 1'b0;
        drv    <= 1'b0;
        fwdEn  <= 1'b0;
        dsCsNq <= '1;
      end else begin
        if (rise) begin
          if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
          preselPulse <= (bitCnt == CNT_W'(BYTE_W - 1)) && (state == ST_PRESEL);
          instrPulse  <= (bitCnt == CNT_W'(2*BYTE_W - 1)) && (state == ST_LOCAL);
          dataPulse   <= (bitCnt == CNT_W'(FRAME_BITS - 1)) && (state == ST_LOCAL);
        end
        if (preselPulse) begin
          if (rxByte == LOCAL_CODE) begin
            state <= ST_LOCAL;
          end else if (|tgtHit) begin
            state  <= ST_FWD;
            dsCsNq <= ~tgtHit;
          end else begin
            state <= ST_DROP;
          end
        end
        if (instrPulse) isRead <= rxByte[BYTE_W-1];
        if (fall) begin
          if (state == ST_FWD) fwdEn <= 1'b1;
          if (state == ST_LOCAL && isRead && bitCnt >= CNT_W'(2*BYTE_W)) drv <= 1'b1;
        end
      end
    end
  end

  assign stb.sample     = rise;
  assign stb.bitIn      = sdioS;
  assign stb.latchInstr = instrPulse;
  assign stb.commit     = dataPulse & ~isRead;
  assign stb.shiftTx    = fall & drv;

  assign sdioOe = drv & ~spiCsN;
  assign dsCsN  = dsCsNq;
  assign dsSclk = sclkS & fwdEn;
  assign dsSdo  = sdioS & fwdEn;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~dsCsNq) <= 1); // R6
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DROP) |-> (&dsCsNq && !fwdEn && !drv)); // R7
  AST_DRIVE_ONLY_LOCAL_READ: assert property (@(posedge clk) disable iff (!rstN)
    drv |-> (state == ST_LOCAL && isRead)); // R5
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ncsS) |=> (&dsCsNq && !fwdEn)); // R11
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !sdioOe); // R9
endmodule

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiPreselPkg::*;
#(
  parameter int DIR_W = 4,
  parameter int LED_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          stb,
  input  logic [LED_W-1:0]  statusIn,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdioOut,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic [2*DIR_W-1:0] ioQ,
  output logic [LED_W-1:0]  ledQ,
  output logic              ledOut
);
  logic [1:0]        instrAddr;
  logic [BYTE_W-1:0] txReg;
  logic [BYTE_W-1:0] rdData;

  always_comb begin
    case (rxByte[1:0])
      2'd0:    rdData = BYTE_W'(ctrlQ);
      2'd1:    rdData = BYTE_W'(ioQ);
      2'd2:    rdData = BYTE_W'(ledQ);
      default: rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte    <= '0;
      instrAddr <= '0;
      txReg     <= '0;
      ctrlQ     <= '0;
      ioQ       <= '0;
      ledQ      <= '0;
    end else begin
      if (stb.sample) rxByte <= {rxByte[BYTE_W-2:0], stb.bitIn};
      if (stb.latchInstr) begin
        instrAddr <= rxByte[1:0];
        txReg     <= rdData;
      end else if (stb.shiftTx) begin
        txReg <= {txReg[BYTE_W-2:0], 1'b0};
      end
      if (stb.commit) begin
        case (instrAddr)
          2'd0:    ctrlQ <= rxByte[CTRL_W-1:0];
          2'd1:    ioQ   <= rxByte[2*DIR_W-1:0];
          2'd2:    ledQ  <= rxByte[LED_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign sdioOut = txReg[BYTE_W-1];

  always_comb begin
    ledOut = 1'b0;
    for (int i = LED_W - 1; i >= 0; i--) begin
      if (ledQ[i]) ledOut = statusIn[i];
    end
  end

  AST_CTRL_WRITE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ != $past(ctrlQ)) |-> $past(stb.commit)); // R8
  AST_IO_WRITE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (ioQ != $past(ioQ)) |-> $past(stb.commit)); // R8
  AST_LED_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (ledQ == '0) |-> !ledOut); // R4
endmodule

// File: rtl/spiPreselRouter.sv
module spiPreselRouter
  import spiPreselPkg::*;
#(
  parameter int NUM_TARGETS = 3,
  parameter int DIR_W       = 4,
  parameter int LED_W       = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   spiCsN,
  input  logic                   spiSclk,
  input  logic                   spiSdioIn,
  output logic                   spiSdioOut,
  output logic                   spiSdioOe,
  output logic [NUM_TARGETS-1:0] dsCsN,
  output logic                   dsSclk,
  output logic                   dsSdo,
  input  logic [LED_W-1:0]       statusIn,
  output logic [1:0]             clkSrcSel,
  output logic                   syncSrcSel,
  output logic                   clkRst,
  output logic                   dacRst,
  output logic [DIR_W-1:0]       xcvrDir,
  output logic [DIR_W-1:0]       fanEn,
  output logic [LED_W-1:0]       ledSel,
  output logic                   ledOut
);
  dpStrobeT stb;
  logic [BYTE_W-1:0]  rxByte;
  logic [CTRL_W-1:0]  ctrlQ;
  logic [2*DIR_W-1:0] ioQ;

  spiFrameCtrl #(.NUM_TARGETS(NUM_TARGETS)) uCtrl (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .spiSdioIn(spiSdioIn), .rxByte(rxByte), .stb(stb), .sdioOe(spiSdioOe),
    .dsCsN(dsCsN), .dsSclk(dsSclk), .dsSdo(dsSdo)
  );

  spiRegDatapath #(.DIR_W(DIR_W), .LED_W(LED_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .statusIn(statusIn), .rxByte(rxByte),
    .sdioOut(spiSdioOut), .ctrlQ(ctrlQ), .ioQ(ioQ), .ledQ(ledSel), .ledOut(ledOut)
  );

  assign clkSrcSel  = ctrlQ[1:0];
  assign syncSrcSel = ctrlQ[2];
  assign clkRst     = ctrlQ[3];
  assign dacRst     = ctrlQ[4];
  assign xcvrDir    = ioQ[DIR_W-1:0];
  assign fanEn      = ioQ[2*DIR_W-1:DIR_W];
endmodule

// File: tb/sim_spiPreselRouter.sv
module sim_spiPreselRouter;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1, spiSclk = 1'b0, spiSdioIn = 1'b0;
  logic spiSdioOut, spiSdioOe, dsSclk, dsSdo;
  logic [2:0] dsCsN;
  logic [4:0] statusIn = 5'b0;
  logic [1:0] clkSrcSel;
  logic syncSrcSel, clkRst, dacRst, ledOut;
  logic [3:0] xcvrDir, fanEn;
  logic [4:0] ledSel;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [7:0] rdByte;
  logic oeSeen;
  logic [2:0] csLowSeen;
  int fwdCount;
  logic [15:0] fwdBits;

  always #5 clk = ~clk;

  spiPreselRouter u0 (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk), .spiSdioIn(spiSdioIn),
    .spiSdioOut(spiSdioOut), .spiSdioOe(spiSdioOe), .dsCsN(dsCsN), .dsSclk(dsSclk),
    .dsSdo(dsSdo), .statusIn(statusIn), .clkSrcSel(clkSrcSel), .syncSrcSel(syncSrcSel),
    .clkRst(clkRst), .dacRst(dacRst), .xcvrDir(xcvrDir), .fanEn(fanEn),
    .ledSel(ledSel), .ledOut(ledOut)
  );

  always @(negedge clk) if (!spiCsN) csLowSeen |= ~dsCsN;
  always @(posedge dsSclk) begin
    fwdCount++;
    fwdBits = {fwdBits[14:0], dsSdo};
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spiXfer(input logic [31:0] pat, input int nBits, input bit earlyRaise);
    rdByte = 0; oeSeen = 0; csLowSeen = 0; fwdCount = 0; fwdBits = 0;
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      spiSdioIn = pat[nBits-1-i];
      repeat (HALF) @(negedge clk);
      if (i >= 16) begin
        rdByte = {rdByte[6:0], spiSdioOut};
        oeSeen |= spiSdioOe;
      end
      spiSclk = 1'b1;
      if (earlyRaise && i == nBits - 1) begin
        @(negedge clk);
        spiCsN = 1'b1;
      end
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    spiSdioIn = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic testReset();
    check(clkSrcSel == 0 && !syncSrcSel && !clkRst && !dacRst, "R1 ctrl", {clkSrcSel, syncSrcSel, clkRst, dacRst}, 0);
    check(xcvrDir == 0 && fanEn == 0 && ledSel == 0 && !ledOut, "R1 regs", {xcvrDir, fanEn, ledSel}, 0);
    check(dsCsN == 3'b111 && !dsSclk && !spiSdioOe, "R1 pins", {dsCsN, dsSclk, spiSdioOe}, 32'h1c);
  endtask

  task automatic testCtrlWrite();
    spiXfer({8'h00, 8'h00, 8'h1B}, 24, 0);
    check(clkSrcSel == 2'b11 && !syncSrcSel && clkRst && dacRst, "R2 reg0 fields",
          {clkSrcSel, syncSrcSel, clkRst, dacRst}, 32'h1B);
    spiXfer({8'h00, 8'h80, 8'h00}, 24, 0);
    check(rdByte == 8'h1B, "R2 reg0 readback", rdByte, 8'h1B);
  endtask

  task automatic testIoAlias();
    spiXfer({8'h00, 8'h7D, 8'hA5}, 24, 0);
    check(xcvrDir == 4'h5 && fanEn == 4'hA, "R3 R10 dir/fan via aliased address", {fanEn, xcvrDir}, 8'hA5);
    spiXfer({8'h00, 8'h81, 8'h00}, 24, 0);
    check(rdByte == 8'hA5 && oeSeen, "R5 read reg1", {oeSeen, rdByte}, 9'h1A5);
  endtask

  task automatic testLed();
    statusIn = 5'b00101;
    spiXfer({8'h00, 8'h02, 8'h01}, 24, 0);
    check(ledOut == 1'b1, "R4 ledSel=00001 picks status0", ledOut, 1);
    statusIn = 5'b00100;
    @(negedge clk);
    check(ledOut == 1'b0, "R4 follows status0", ledOut, 0);
    spiXfer({8'h00, 8'h02, 8'h14}, 24, 0);
    check(ledOut == 1'b1 && ledSel == 5'h14, "R4 ledSel=10100 picks status2", {ledSel, ledOut}, {5'h14, 1'b1});
    spiXfer({8'h00, 8'h02, 8'h00}, 24, 0);
    check(ledOut == 1'b0, "R4 ledSel=0", ledOut, 0);
  endtask

  task automatic testForward();
    spiXfer({8'h02, 16'hC3A5}, 24, 0);
    check(csLowSeen == 3'b010, "R6 only target1 selected", csLowSeen, 3'b010);
    check(fwdCount == 16 && fwdBits == 16'hC3A5, "R6 forwarded bits", {fwdCount[15:0], fwdBits}, {16'd16, 16'hC3A5});
    check(xcvrDir == 4'h5 && fanEn == 4'hA, "R6 locals untouched", {fanEn, xcvrDir}, 8'hA5);
    check(dsCsN == 3'b111 && !dsSclk, "R11 release after frame", dsCsN, 3'b111);
    spiXfer({8'h00, 8'h81, 8'h00}, 24, 0);
    check(rdByte == 8'hA5 && csLowSeen == 0, "R11 next frame decoded afresh", rdByte, 8'hA5);
  endtask

  task automatic testUnmatched();
    spiXfer({8'h09, 8'h01, 8'h3C}, 24, 0);
    check(csLowSeen == 0 && fwdCount == 0 && !oeSeen, "R7 code 09 ignored", {csLowSeen, fwdCount[3:0]}, 0);
    check(xcvrDir == 4'h5 && fanEn == 4'hA, "R7 no register change", {fanEn, xcvrDir}, 8'hA5);
    spiXfer({8'h80, 8'h81, 8'h00}, 24, 0);
    check(csLowSeen == 0 && !oeSeen, "R7 code 80 ignored", {csLowSeen, oeSeen}, 0);
  endtask

  task automatic testAbortAndRace();
    spiXfer({8'h00, 8'h01, 8'h3C} >> 4, 20, 0);
    check(xcvrDir == 4'h5 && fanEn == 4'hA, "R8 abort at 20 bits", {fanEn, xcvrDir}, 8'hA5);
    spiXfer({8'h00, 8'h01, 8'h3C} >> 1, 23, 0);
    check(xcvrDir == 4'h5 && fanEn == 4'hA, "R8 abort at 23 bits", {fanEn, xcvrDir}, 8'hA5);
    spiXfer({8'h00, 8'h01, 8'h3C}, 24, 1);
    check(xcvrDir == 4'hC && fanEn == 4'h3, "R8 write with early raise", {fanEn, xcvrDir}, 8'h3C);
  endtask

  task automatic testOeRelease();
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      spiSdioIn = (i == 8 || i == 15);
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    check(spiSdioOe == 1'b1, "R5 driver on mid read", spiSdioOe, 1);
    spiCsN = 1'b1;
    @(negedge clk);
    check(spiSdioOe == 1'b0, "R9 driver off on abort", spiSdioOe, 0);
    repeat (12) @(negedge clk);
  endtask

  task automatic testAddr3();
    spiXfer({8'h00, 8'h03, 8'hFF}, 24, 0);
    check(xcvrDir == 4'hC && ledSel == 5'h0 && clkSrcSel == 2'b11, "R10 addr3 write ignored",
          {ledSel, xcvrDir}, {5'h0, 4'hC});
    spiXfer({8'h00, 8'hFF, 8'h00}, 24, 0);
    check(rdByte == 8'h00 && oeSeen, "R10 addr3 reads 0", rdByte, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testCtrlWrite();
    testIoAlias();
    testLed();
    testForward();
    testUnmatched();
    testAbortAndRace();
    testOeRelease();
    testAddr3();
    finishRun();
  end
endmodule